// File: doc/BRIEF.md
# Function Chain Trigger Arbiter

This block sits in front of a routine sequencer. It collects trigger requests for 24 processing routines and picks the one that runs next. Sixteen triggers come from host command bits and eight come from FIFO interrupt lines. Four of those lines belong to FIFO group A and four to group B. A rising edge on a trigger line sets that trigger's pending bit. The block then masks the pending set with a per-trigger enable and arbitrates the rest in two levels:

- The priority class is checked first.
- Inside a class, the fixed source order decides.

The block presents the winning index with a valid strobe. It holds that index until the sequencer pulses done.

A small register port gives the host four registers: enables, priorities, a read-only pending view, and a control word. The control word can pause dispatch, resume it, flush all pending work, and report whether a routine is running. Pausing only stops new selections. Pending bits keep collecting, and a routine that is already running finishes normally.

Top module: `fc_trig_arbiter`

## Requirements
- R1: Pending bits and request merging.
  - A rising edge on a trigger line sets that trigger's pending bit on the clock edge that samples it.
  - A line held high does not set the bit again.
  - A further edge while the bit is still set is merged into the existing request, so only one selection results.
- R2: Index map and selection hold.
  - Trigger indices are: commands 0..15 → 0..15, FIFO A0..A3 → 16..19, FIFO B0..B3 → 20..23.
  - After a selection, `sel_valid_o` is high and `sel_idx_o` holds the chosen index, unchanged, until completion.
- R3: An eligible high-priority trigger is always selected before any normal-priority one. Priority register bit n = 1 marks trigger n as high priority.
- R4: Within one priority class the lowest index wins. This gives command triggers precedence over FIFO A, FIFO A precedence over FIFO B, and within a group the lower number wins.
- R5: Masking by the enable register.
  - A trigger whose enable bit is 0 is never selected, but its pending bit is still set and reported.
  - Setting the enable bit makes it selectable from the next cycle.
- R6: The status register reads back the pending bits, with bit n corresponding to trigger n.
- R7: Completion pulse.
  - A `done_i` pulse while a routine is running clears that trigger's pending bit and drops `sel_valid_o` on the same edge.
  - The next selection can appear one cycle later at the earliest.
  - `done_i` while idle has no effect.
- R8: Pause.
  - While paused, no new selection is made and pending bits keep accumulating.
  - A routine already running stays valid until its done pulse.
- R9: Writing resume clears the pause. The next selection then appears one clock after that write.
- R10: Writing the reset control bit does the following, while leaving the enable and priority registers unchanged:
  - clears every pending bit;
  - clears the pause;
  - drops a running selection.
- R11: After `rst_ni` is asserted, the following are all zero:
  - the enable, priority and status registers;
  - the control word;
  - `sel_valid_o`.
- R12: Register map (`reg_addr_i`).
  - Address 0: enable. Address 1: priority. Address 2: status, read-only, so writes are ignored.
  - Address 3: control.
    - Write bit 0 = 1 to pause and bit 1 = 1 to resume; if both are written, pause wins.
    - Bit 2 reads as running.
    - Write bit 3 = 1 for the reset action.
    - Bit 0 reads as paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_trig_i | input | 16 | Host command trigger lines |
| fifo_a_irq_i | input | 4 | FIFO group A interrupt lines |
| fifo_b_irq_i | input | 4 | FIFO group B interrupt lines |
| done_i | input | 1 | Completion pulse for the running routine |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| sel_valid_o | output | 1 | A routine is selected and running |
| sel_idx_o | output | 5 | Index of the selected routine |

## Verification
The assertions assume the following about the inputs:
- `done_i` is a single-cycle pulse that acknowledges the routine currently shown.
- The trigger lines are synchronous to `clk_i`.
- The control word is not written with both reset and a new trigger edge in the same cycle.

The stimulus respects these assumptions:
- It drives all inputs one time unit after a rising edge.
- It pulses `done_i` only while `sel_valid_o` is high, except in the one scenario that checks that an idle `done_i` is ignored.
- It builds multi-trigger contention while paused, so that the whole competing set is pending before arbitration is released.

// File: rtl/fc_arb_pkg.sv
package fc_arb_pkg;
  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_PRIO = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_PAUSE  = 0;
  localparam int unsigned CTRL_RESUME = 1;
  localparam int unsigned CTRL_RUN    = 2;
  localparam int unsigned CTRL_FLUSH  = 3;
endpackage

// File: rtl/fc_pend_bank.sv
module fc_pend_bank #(
  parameter int unsigned N = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  input  logic         flush_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q, pend_q, rise;

  assign rise = req_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= req_i;
      if (flush_i) pend_q <= '0;
      else         pend_q <= (pend_q & ~clr_i) | rise;  // new edge beats clear
    end
  end

  assign pend_o = pend_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_pend_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_q[g]) |-> $past(clr_i[g] || flush_i));
  end

  assert_clr_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_i));
endmodule

// File: rtl/fc_lowest_pick.sv
module fc_lowest_pick #(
  parameter int unsigned W  = 24,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  assert_pick_lowest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (req_i[idx_o] && ((req_i & ((W'(1) << idx_o) - W'(1))) == '0)));
endmodule

// File: rtl/fc_trig_arbiter.sv
module fc_trig_arbiter
  import fc_arb_pkg::*;
#(
  parameter int unsigned N_CMD = 16,
  parameter int unsigned N_FA  = 4,
  parameter int unsigned N_FB  = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned N    = N_CMD + N_FA + N_FB,
  localparam int unsigned IW   = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CMD-1:0] cmd_trig_i,
  input  logic [N_FA-1:0]  fifo_a_irq_i,
  input  logic [N_FB-1:0]  fifo_b_irq_i,
  input  logic             done_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             sel_valid_o,
  output logic [IW-1:0]    sel_idx_o
);
  logic [N-1:0]  en_q, prio_q, pend, elig, elig_hi, clr_vec, trig;
  logic          paused_q, run_q;
  logic [IW-1:0] grant_q, hi_idx, lo_idx, pick_idx;
  logic          any_hi, any_lo, done_acc, flush, grant_fire;
  logic          wr_en, wr_prio, wr_ctrl;

  // index order: commands, then FIFO A, then FIFO B
  assign trig = {fifo_b_irq_i, fifo_a_irq_i, cmd_trig_i};

  assign wr_en   = reg_we_i && (reg_addr_i == REG_EN);
  assign wr_prio = reg_we_i && (reg_addr_i == REG_PRIO);
  assign wr_ctrl = reg_we_i && (reg_addr_i == REG_CTRL);
  assign flush   = wr_ctrl && reg_wdata_i[CTRL_FLUSH];

  assign done_acc = done_i && run_q;
  for (genvar g = 0; g < N; g++) begin : g_clr
    assign clr_vec[g] = done_acc && (grant_q == IW'(g));
  end

  fc_pend_bank #(.N(N)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (trig),
    .clr_i   (clr_vec),
    .flush_i (flush),
    .pend_o  (pend)
  );

  assign elig    = pend & en_q;
  assign elig_hi = elig & prio_q;

  fc_lowest_pick #(.W(N)) u_pick_hi (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .req_i (elig_hi), .found_o (any_hi), .idx_o (hi_idx)
  );

  fc_lowest_pick #(.W(N)) u_pick_lo (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .req_i (elig), .found_o (any_lo), .idx_o (lo_idx)
  );

  assign pick_idx   = any_hi ? hi_idx : lo_idx;
  assign grant_fire = !run_q && !paused_q && any_lo && !flush;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      prio_q   <= '0;
      paused_q <= 1'b0;
      run_q    <= 1'b0;
      grant_q  <= '0;
    end else begin
      if (wr_en)   en_q   <= reg_wdata_i[N-1:0];
      if (wr_prio) prio_q <= reg_wdata_i[N-1:0];
      if (flush) begin
        paused_q <= 1'b0;
        run_q    <= 1'b0;
      end else begin
        if (wr_ctrl && reg_wdata_i[CTRL_RESUME]) paused_q <= 1'b0;
        if (wr_ctrl && reg_wdata_i[CTRL_PAUSE])  paused_q <= 1'b1;
        if (done_acc) run_q <= 1'b0;
        else if (grant_fire) begin
          run_q   <= 1'b1;
          grant_q <= pick_idx;
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_EN:   reg_rdata_o[N-1:0] = en_q;
      REG_PRIO: reg_rdata_o[N-1:0] = prio_q;
      REG_STAT: reg_rdata_o[N-1:0] = pend;
      REG_CTRL: begin
        reg_rdata_o[CTRL_PAUSE] = paused_q;
        reg_rdata_o[CTRL_RUN]   = run_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign sel_valid_o = run_q;
  assign sel_idx_o   = grant_q;

  assert_idx_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> $stable(grant_q));

  assert_hi_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_fire && |elig_hi) |-> prio_q[pick_idx]);

  assert_grant_elig_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_fire |-> (en_q[pick_idx] && pend[pick_idx]));

  assert_no_grant_paused_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> !$past(paused_q));
endmodule

// File: tb/fc_trig_arbiter_tb.sv
module fc_trig_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ALL_EN = 32'h00FF_FFFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cmd_trig_i = '0;
  logic [3:0]  fifo_a_irq_i = '0;
  logic [3:0]  fifo_b_irq_i = '0;
  logic        done_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        sel_valid_o;
  logic [4:0]  sel_idx_o;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fc_trig_arbiter u_dut (
    .clk_i, .rst_ni, .cmd_trig_i, .fifo_a_irq_i, .fifo_b_irq_i, .done_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .sel_valid_o, .sel_idx_o
  );

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic pulse(logic [15:0] c, logic [3:0] fa, logic [3:0] fb);
    cmd_trig_i = c; fifo_a_irq_i = fa; fifo_b_irq_i = fb;
    step();
    cmd_trig_i = '0; fifo_a_irq_i = '0; fifo_b_irq_i = '0;
  endtask

  task automatic finish_run();
    done_i = 1'b1; step(); done_i = 1'b0;
  endtask

  task automatic chk_sel(string req, logic v, logic [4:0] idx);
    chk(req, {31'd0, sel_valid_o}, {31'd0, v});
    if (v) chk(req, {27'd0, sel_idx_o}, {27'd0, idx});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_ni = 1'b0; step(); step(); rst_ni = 1'b1; step();
    chk_sel("R11 valid", 1'b0, 5'd0);
    rd(2'd0, d); chk("R11 enable", d, 0);
    rd(2'd1, d); chk("R11 prio", d, 0);
    rd(2'd2, d); chk("R11 status", d, 0);
    rd(2'd3, d); chk("R11 ctrl", d, 0);
    wr(2'd0, ALL_EN);
    rd(2'd0, d); chk("R12 enable rb", d, ALL_EN);
  endtask

  task automatic t_latch_merge();
    logic [31:0] d;
    wr(2'd3, 32'h1);
    rd(2'd3, d); chk("R12 paused rb", d, 32'h1);
    cmd_trig_i[3] = 1'b1; step();
    rd(2'd2, d); chk("R6 status", d, 32'h8);
    step(); step();
    rd(2'd2, d); chk("R1 held level", d, 32'h8);
    cmd_trig_i[3] = 1'b0; step();
    cmd_trig_i[3] = 1'b1; step(); cmd_trig_i[3] = 1'b0;
    rd(2'd2, d); chk("R1 merge", d, 32'h8);
    chk_sel("R8 paused no sel", 1'b0, 5'd0);
    wr(2'd3, 32'h2);
    chk_sel("R9 not yet", 1'b0, 5'd0);
    step();
    chk_sel("R9 sel after resume", 1'b1, 5'd3);
    rd(2'd3, d); chk("R12 running rb", d, 32'h4);
    finish_run();
    chk_sel("R7 valid drop", 1'b0, 5'd0);
    rd(2'd2, d); chk("R7 pend clr", d, 0);
    step();
    chk_sel("R1 single run", 1'b0, 5'd0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    wr(2'd3, 32'h1);
    pulse(16'h0200, 4'b0100, 4'b0010);
    rd(2'd2, d); chk("R6 multi", d, (32'd1 << 21) | (32'd1 << 18) | (32'd1 << 9));
    wr(2'd3, 32'h2); step();
    chk_sel("R4 cmd first", 1'b1, 5'd9);
    finish_run(); step();
    chk_sel("R4 fifo A next", 1'b1, 5'd18);
    finish_run(); step();
    chk_sel("R2 fifo B idx", 1'b1, 5'd21);
    finish_run(); step();
    chk_sel("R4 drained", 1'b0, 5'd0);
  endtask

  task automatic t_prio();
    wr(2'd1, 32'd1 << 22);
    wr(2'd3, 32'h1);
    pulse(16'h0001, 4'b0000, 4'b0100);
    wr(2'd3, 32'h2); step();
    chk_sel("R3 high first", 1'b1, 5'd22);
    step(); step();
    chk_sel("R2 hold idx", 1'b1, 5'd22);
    finish_run(); step();
    chk_sel("R3 normal after", 1'b1, 5'd0);
    finish_run();
    wr(2'd1, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(2'd0, ALL_EN & ~32'h2);
    pulse(16'h0002, 4'b0000, 4'b0000);
    step(); step();
    chk_sel("R5 masked", 1'b0, 5'd0);
    rd(2'd2, d); chk("R5 still pend", d, 32'h2);
    wr(2'd0, ALL_EN); step();
    chk_sel("R5 unmasked", 1'b1, 5'd1);
    finish_run();
  endtask

  task automatic t_pause_flush();
    logic [31:0] d;
    pulse(16'h0010, 4'b0000, 4'b0000); step();
    chk_sel("R8 run start", 1'b1, 5'd4);
    wr(2'd3, 32'h1);
    chk_sel("R8 run kept", 1'b1, 5'd4);
    pulse(16'h0020, 4'b0000, 4'b0000);
    finish_run(); step(); step();
    chk_sel("R8 no new sel", 1'b0, 5'd0);
    pulse(16'h0040, 4'b0000, 4'b0000);
    rd(2'd2, d); chk("R8 accumulate", d, 32'h60);
    wr(2'd3, 32'h2); step();
    chk_sel("R9 resume sel", 1'b1, 5'd5);
    wr(2'd3, 32'h9);
    chk_sel("R10 drop run", 1'b0, 5'd0);
    rd(2'd2, d); chk("R10 pend clr", d, 0);
    rd(2'd3, d); chk("R10 ctrl clr", d, 0);
    rd(2'd0, d); chk("R10 en kept", d, ALL_EN);
    step();
    chk_sel("R10 idle", 1'b0, 5'd0);
  endtask

  task automatic t_idle_done_ro();
    logic [31:0] d;
    wr(2'd3, 32'h1);
    pulse(16'h0080, 4'b0000, 4'b0000);
    finish_run();
    rd(2'd2, d); chk("R7 idle done ignored", d, 32'h80);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R12 status ro", d, 32'h80);
    wr(2'd3, 32'h8);
    rd(2'd2, d); chk("R10 flush", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!ended) begin
      ended = 1;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latch_merge();
    t_order();
    t_prio();
    t_mask();
    t_pause_flush();
    t_idle_done_ro();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule